// File: doc/BRIEF.md
# ECC Error Status Register Unit

This block gathers error reports from three ECC-protected memories and presents them to a host as a single 32-bit status word. The three memories are a packet buffer, a receive descriptor memory and a transmit descriptor memory. Each memory's ECC checker pulses one input for a correctable error and another for an uncorrectable error. The unit keeps a count of each error class across all memories, and a sticky flag for each of the six source/class pairs. It also holds an ECC enable bit that the memories' checkers can use.

The host reads the word through `rd_data`, which always shows the current state. Asserting `rd_en` for one cycle marks that cycle's value as consumed. At the next clock edge the counters and flags are cleared, except for any event that arrives in the same cycle. A write updates only the enable bit. The interface carries single-cycle register accesses rather than a data stream, so it has no valid/ready handshake and applies no back-pressure: a read or write is accepted in every cycle it is presented.

Top module: `ecc_err_status`

## Requirements
- R1: Bits 7:0 count correctable errors. Each cycle, the count grows by the number of correctable pulses that are asserted at once on `pb_cor_err`, `rxd_cor_err` and `txd_cor_err`, and it holds at 255 once it reaches that value. The new count is visible the cycle after the pulses.
- R2: Bits 15:8 count uncorrectable errors in the same way, using `pb_unc_err`, `rxd_unc_err` and `txd_unc_err`, and hold at 255.
- R3: Both counts are 0 after reset. A cycle with `rd_en` high returns the current word on `rd_data` and then clears the counts at the next clock edge.
- R4: Bit 16 is the ECC enable. It is 1 after reset. A cycle with `wr_en` high loads `wr_data[16]` into it, and the new value is visible the next cycle.
- R5: Bits 25:17 always read as 0.
- R6: Status flags are sticky once set, and each is set the cycle after its pulse. The bit mapping is:
  - bit 26: packet buffer correctable
  - bit 27: packet buffer uncorrectable
  - bit 28: receive descriptor correctable
  - bit 29: receive descriptor uncorrectable
  - bit 30: transmit descriptor correctable
  - bit 31: transmit descriptor uncorrectable
- R7: All flags are 0 after reset and are cleared by a read, in the same way as the counts.
- R8: An event in the same cycle as a read takes priority over the clear. The count reloads with the number of pulses in that cycle, and the flag for that event stays set.
- R9: While the enable bit is 0, error pulses change neither the counts nor the flags.
- R10: A write leaves the counts, flags and reserved bits unchanged, whatever `wr_data` holds in those positions.
- R11: Output `ecc_en` always equals bit 16 of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe; clears counts and flags at the next edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; only bit 16 is used |
| rd_data | output | 32 | Current status word |
| pb_cor_err | input | 1 | Packet buffer correctable error pulse |
| pb_unc_err | input | 1 | Packet buffer uncorrectable error pulse |
| rxd_cor_err | input | 1 | Receive descriptor correctable error pulse |
| rxd_unc_err | input | 1 | Receive descriptor uncorrectable error pulse |
| txd_cor_err | input | 1 | Transmit descriptor correctable error pulse |
| txd_unc_err | input | 1 | Transmit descriptor uncorrectable error pulse |
| ecc_en | output | 1 | Current ECC enable |

## Verification
The main collision is a host read that clears state in the same cycle that error pulses set it. The bench provokes this by raising `rd_en` together with two uncorrectable pulses. It then expects the read to return the pre-clear word, and the following read to show a count of 2 with both flags still set. A second overlap, a write arriving on top of existing counts and flags, is judged by reading back afterwards and confirming that only the enable bit moved.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned N_SRC    = 3;
  localparam int unsigned COR_LSB  = 0;
  localparam int unsigned UNC_LSB  = COR_LSB + CNT_W;
  localparam int unsigned ENA_BIT  = UNC_LSB + CNT_W;
  localparam int unsigned FLAG_LSB = 26;
  localparam int unsigned N_FLAG   = 2 * N_SRC;
  localparam int unsigned RSV_LSB  = ENA_BIT + 1;
  localparam int unsigned RSV_W    = FLAG_LSB - RSV_LSB;

  typedef enum logic [1:0] {SRC_PB = 2'd0, SRC_RXD = 2'd1, SRC_TXD = 2'd2} src_e;
endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NIN   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NIN-1:0]   inc,
  output logic [WIDTH-1:0] cnt
);
  localparam int unsigned SUM_W = WIDTH + $clog2(NIN + 1);
  localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << WIDTH) - 1);

  logic [SUM_W-1:0] n_inc;
  logic [SUM_W-1:0] sum;

  always_comb begin
    n_inc = '0;
    for (int i = 0; i < int'(NIN); i++) n_inc = n_inc + SUM_W'(inc[i]);
    sum = (clr ? '0 : SUM_W'(cnt)) + n_inc;
    if (sum > MAXV) sum = MAXV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sum[WIDTH-1:0];
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt && !clr) |=> &cnt); // R1
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt)); // R1
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc == '0) |=> cnt == '0); // R3
  AST_CNT_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc != '0) |=> cnt == WIDTH'($countones($past(inc)))); // R8
endmodule

// File: rtl/ecc_sticky_flags.sv
module ecc_sticky_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < int'(N); g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr)    flags[g] <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (flags & $past(flags)) == $past(flags)); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set != '0 |=> (flags & $past(set)) == $past(set)); // R8
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> flags == '0); // R7
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pb_cor_err,
  input  logic              pb_unc_err,
  input  logic              rxd_cor_err,
  input  logic              rxd_unc_err,
  input  logic              txd_cor_err,
  input  logic              txd_unc_err,
  output logic              ecc_en
);
  logic [N_SRC-1:0]  cor_raw, unc_raw, cor_g, unc_g;
  logic [N_FLAG-1:0] flag_set, flags;
  logic [CNT_W-1:0]  cor_cnt, unc_cnt;
  logic              en_q;

  always_comb begin
    cor_raw = '0;
    unc_raw = '0;
    cor_raw[SRC_PB]  = pb_cor_err;
    unc_raw[SRC_PB]  = pb_unc_err;
    cor_raw[SRC_RXD] = rxd_cor_err;
    unc_raw[SRC_RXD] = rxd_unc_err;
    cor_raw[SRC_TXD] = txd_cor_err;
    unc_raw[SRC_TXD] = txd_unc_err;
    cor_g = en_q ? cor_raw : '0;
    unc_g = en_q ? unc_raw : '0;
  end

  for (genvar s = 0; s < int'(N_SRC); s++) begin : g_map
    assign flag_set[2*s]   = cor_g[s];
    assign flag_set[2*s+1] = unc_g[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b1;
    else if (wr_en) en_q <= wr_data[ENA_BIT];
  end

  ecc_sat_counter #(.WIDTH(CNT_W), .NIN(N_SRC)) u_cor_cnt (
    .clk(clk), .rst_n(rst_n), .clr(rd_en), .inc(cor_g), .cnt(cor_cnt));

  ecc_sat_counter #(.WIDTH(CNT_W), .NIN(N_SRC)) u_unc_cnt (
    .clk(clk), .rst_n(rst_n), .clr(rd_en), .inc(unc_g), .cnt(unc_cnt));

  ecc_sticky_flags #(.N(N_FLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(rd_en), .set(flag_set), .flags(flags));

  always_comb begin
    rd_data = '0;
    rd_data[COR_LSB +: CNT_W]   = cor_cnt;
    rd_data[UNC_LSB +: CNT_W]   = unc_cnt;
    rd_data[ENA_BIT]            = en_q;
    rd_data[FLAG_LSB +: N_FLAG] = flags;
  end

  assign ecc_en = en_q;

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ecc_en == $past(wr_data[ENA_BIT])); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ecc_en)); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_en && !rd_en) |=> $stable(rd_data[DATA_W-1:FLAG_LSB])
                         && $stable(rd_data[ENA_BIT-1:0])); // R9
  AST_WRITE_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !(|cor_raw) && !(|unc_raw)) |=>
      $stable(rd_data[DATA_W-1:FLAG_LSB]) && $stable(rd_data[ENA_BIT-1:0])); // R10
endmodule

// File: tb/ecc_err_status_tb_top.sv
module ecc_err_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  ev = '0;
  logic        ecc_en;
  int checks = 0, failures = 0;
  bit  done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  // ev bit order: {txd_unc, txd_cor, rxd_unc, rxd_cor, pb_unc, pb_cor}
  ecc_err_status dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data),
    .pb_cor_err(ev[0]), .pb_unc_err(ev[1]),
    .rxd_cor_err(ev[2]), .rxd_unc_err(ev[3]),
    .txd_cor_err(ev[4]), .txd_unc_err(ev[5]),
    .ecc_en(ecc_en));

  task automatic cyc(input bit rd, input bit wr, input logic [31:0] wd, input logic [5:0] e);
    @(posedge clk); #2;
    rd_en = rd; wr_en = wr; wr_data = wd; ev = e;
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0);
  endtask

  task automatic rd_exp(input logic [31:0] exp, input string tag, input logic [5:0] e = '0);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    cyc(1, 0, '0, e);
    idle();
  endtask

  task automatic chk_en(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (ecc_en !== exp) begin
      failures++;
      $display("FAIL %s ecc_en actual=%0b expected=%0b", tag, ecc_en, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read cycle
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", rd_data);
      end else begin
        it = sb_q.pop_front();
        if (rd_data !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle();
    rd_exp(32'h0001_0000, "R3 R4 R5 R7 reset word");
    chk_en(1'b1, "R11 reset enable");
    // single pulse
    cyc(0, 0, '0, 6'b000001); idle();
    rd_exp(32'h0401_0001, "R1 R6 one pb correctable");
    rd_exp(32'h0001_0000, "R3 R7 cleared by read");
    // all six at once
    cyc(0, 0, '0, 6'b111111); idle();
    rd_exp(32'hFC01_0303, "R1 R2 R6 all sources");
    rd_exp(32'h0001_0000, "R7 clear after all");
    // correctable saturation: 100 x 3
    for (int i = 0; i < 100; i++) cyc(0, 0, '0, 6'b010101);
    idle();
    rd_exp(32'h5401_00FF, "R1 correctable saturates");
    // uncorrectable saturation: 90 x 3
    for (int i = 0; i < 90; i++) cyc(0, 0, '0, 6'b101010);
    idle();
    rd_exp(32'hA801_FF00, "R2 uncorrectable saturates");
    // read collides with events
    rd_exp(32'h0001_0000, "R8 read word before clear", 6'b101000);
    rd_exp(32'hA001_0200, "R8 event beats clear");
    // write with counts present
    cyc(0, 0, '0, 6'b000011); idle();
    cyc(0, 1, 32'hFFFF_FFFF, '0); idle();
    rd_exp(32'h0C01_0101, "R10 write keeps counts and flags");
    // disable
    cyc(0, 1, 32'hFFFE_FFFF, '0); idle();
    chk_en(1'b0, "R11 enable follows write");
    rd_exp(32'h0000_0000, "R4 R10 enable cleared only");
    cyc(0, 0, '0, 6'b111111); cyc(0, 0, '0, 6'b111111); idle();
    rd_exp(32'h0000_0000, "R9 disabled ignores pulses");
    cyc(0, 1, 32'h0001_0000, '0); idle();
    chk_en(1'b1, "R4 R11 re-enable");
    cyc(0, 0, '0, 6'b100000); idle();
    rd_exp(32'h8001_0100, "R2 R6 txd uncorrectable");
    repeat (3) idle();
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R3 scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    done = 1;
  end

  initial begin
    int cyc_n = 0;
    while (!done && cyc_n < 20000) begin
      @(posedge clk);
      cyc_n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc_n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule